// File: doc/BRIEF.md
# Direct-Mapped Address Translation Unit

This block translates virtual addresses for a small processor core. It keeps two independent direct-mapped lookup tables: one serves instruction fetches and one serves loads and stores. Each table slot holds two words. The tag word carries a virtual page number and a valid flag. The mapping word carries a physical page number and permission flags. A request gives the unit a virtual address, an access kind and the current privilege level. One clock later the unit returns the physical address, the rights granted, a result code and an exception class. On any fault it also updates a register that holds the faulting virtual address.

Software loads table slots through a small write port that selects the table, the word and the slot. Each table can be switched off with its own enable input; with the enable low, addresses pass through unchanged. Supervisor accesses to the lowest 8 KB never consult a table. Faults are reported in two classes: table misses, which cover both a tag mismatch and a valid tag that is cleared, and protection faults, which cover missing rights. This lets a handler refill the table in the first case and deny the access in the second.

Top module: `tlb_xlate_unit`

## Requirements
- R1: The slot consulted is vaddr[18:13], the low 6 bits of the virtual page number vaddr[31:13]. There is exactly one slot per table for each index, and the page offset is vaddr[12:0].
- R2: When the tag word bits [31:13] differ from vaddr[31:13], the result code is 1 (no match).
- R3: When the tag word page number matches but tag bit 0 (valid) is 0, the result code is 2 (invalid).
- R4: A fetch takes its execute right from mapping bit 7 in supervisor mode and from mapping bit 6 in user mode. A fetch without that right gives result code 3 (bad address).
- R5: A data access takes its rights from mapping bits 8 (read) and 9 (write) in supervisor mode, and from bits 6 (read) and 7 (write) in user mode. A load without read rights gives code 3. A store without write rights also gives code 3.
- R6: On a translated success (code 0), rsp_paddr = {mapping[31:13], vaddr[12:0]}. rsp_rights is {exec, write, read} in bits 2..0: a fetch reports only bit 2, and a data access reports only bits 1..0.
- R7: A supervisor access with vaddr below 0x2000 bypasses the tables even when they are enabled. It returns paddr = vaddr, rights 3'b011 and code 0. The address 0x2000 itself is looked up in the table.
- R8: rsp_exc encodes the exception class. Codes 1 and 2 give 1 (instruction miss) for a fetch and 2 (data miss) otherwise. Code 3 gives 3 (instruction page fault) for a fetch and 4 (data page fault) otherwise. Code 0 gives 0.
- R9: fault_addr takes the request's vaddr on every response with a nonzero code, and holds its value otherwise.
- R10: Reset clears every slot of both tables to zero, clears fault_addr and keeps rsp_valid low. With the enable for the access kind low (kind 0 uses itlb_en; kinds 1 and 2 use dtlb_en), the address passes through with rights 3'b011 and code 0.
- R11: rsp_valid is a one-cycle pulse in the cycle after each cycle with req_valid high, and the response fields refer to that request. A faulted response carries paddr 0 and rights 0.
- R12: wr_tlb 0 writes the fetch table and 1 writes the data table; wr_word 0 selects the tag word and 1 the mapping word. A write to one table never changes lookups in the other. Access kind 0 is a fetch, 1 a load and 2 a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| itlb_en | input | 1 | Enables fetch translation |
| dtlb_en | input | 1 | Enables data translation |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_super | input | 1 | Supervisor privilege |
| wr_en | input | 1 | Table write strobe |
| wr_tlb | input | 1 | 0 fetch table, 1 data table |
| wr_word | input | 1 | 0 tag word, 1 mapping word |
| wr_index | input | 6 | Slot to write |
| wr_data | input | 32 | Word to write |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 32 | Physical address |
| rsp_rights | output | 3 | {exec, write, read} granted |
| rsp_code | output | 2 | 0 ok, 1 no match, 2 invalid, 3 bad address |
| rsp_exc | output | 3 | Exception class |
| fault_addr | output | 32 | Last faulting virtual address |

## Verification
Every response field and fault_addr is due exactly one clock edge after the edge that samples req_valid, and a table write takes effect on the edge that samples wr_en. The driver changes inputs on falling edges and pushes the expected response into a queue as it raises the strobe. The monitor pops and compares only on the falling edge where rsp_valid is high, which is half a cycle after the registered outputs change. Writes are finished before the next request is issued, so each lookup sees the table as it stands after that write.

// File: rtl/tlb_xlate_pkg.sv
package tlb_xlate_pkg;

   typedef enum logic [1:0] {
      RES_OK      = 2'd0,
      RES_NOMATCH = 2'd1,
      RES_INVALID = 2'd2,
      RES_BADADDR = 2'd3
   } res_e;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2
   } acc_e;

   typedef enum logic [2:0] {
      EXC_NONE   = 3'd0,
      EXC_IMISS  = 3'd1,
      EXC_DMISS  = 3'd2,
      EXC_IFAULT = 3'd3,
      EXC_DFAULT = 3'd4
   } exc_e;

   // mapping word permission bit positions
   localparam int unsigned PB_USR_X = 6;
   localparam int unsigned PB_SUP_X = 7;
   localparam int unsigned PB_USR_R = 6;
   localparam int unsigned PB_USR_W = 7;
   localparam int unsigned PB_SUP_R = 8;
   localparam int unsigned PB_SUP_W = 9;

   // rights vector positions
   localparam int unsigned RT_R = 0;
   localparam int unsigned RT_W = 1;
   localparam int unsigned RT_X = 2;

endpackage

// File: rtl/tlb_slot_array.sv
module tlb_slot_array #(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned ENTRIES = 64,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_tag,
   input  logic              we_map,
   input  logic [IDX_W-1:0]  widx,
   input  logic [WORD_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx,
   output logic [WORD_W-1:0] rd_tag,
   output logic [WORD_W-1:0] rd_map
);

   logic [WORD_W-1:0] tag_q [ENTRIES];
   logic [WORD_W-1:0] map_q [ENTRIES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            tag_q[i] <= '0;
            map_q[i] <= '0;
         end
      end else begin
         if (we_tag) tag_q[widx] <= wdata;
         if (we_map) map_q[widx] <= wdata;
      end
   end

   assign rd_tag = tag_q[ridx];
   assign rd_map = map_q[ridx];

endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
   import tlb_xlate_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned PG_BITS = 13,
   localparam int unsigned VPN_W  = ADDR_W - PG_BITS
) (
   input  logic [ADDR_W-1:0] tag_w,
   input  logic [ADDR_W-1:0] map_w,
   input  logic [VPN_W-1:0]  vpn,
   input  logic [1:0]        kind,
   input  logic              super_m,
   output logic [1:0]        code,
   output logic [2:0]        rights,
   output logic [VPN_W-1:0]  ppn
);

   logic is_fetch, is_store;
   logic can_x, can_r, can_w;
   logic unused_bits;

   assign is_fetch = (kind == ACC_FETCH);
   assign is_store = (kind == ACC_STORE);

   assign can_x = super_m ? map_w[PB_SUP_X] : map_w[PB_USR_X];
   assign can_r = super_m ? map_w[PB_SUP_R] : map_w[PB_USR_R];
   assign can_w = super_m ? map_w[PB_SUP_W] : map_w[PB_USR_W];

   assign ppn = map_w[ADDR_W-1:PG_BITS];
   assign unused_bits = ^{tag_w[PG_BITS-1:1], map_w[PG_BITS-1:10], map_w[5:0]};

   always_comb begin
      rights = '0;
      if (is_fetch) rights[RT_X] = can_x;
      else begin
         rights[RT_R] = can_r;
         rights[RT_W] = can_w;
      end
      if (tag_w[ADDR_W-1:PG_BITS] != vpn)       code = RES_NOMATCH;
      else if (!tag_w[0])                       code = RES_INVALID;
      else if (is_fetch && !can_x)              code = RES_BADADDR;
      else if (is_store && !can_w)              code = RES_BADADDR;
      else if (!is_fetch && !is_store && !can_r) code = RES_BADADDR;
      else                                      code = RES_OK;
   end

endmodule

// File: rtl/tlb_xlate_unit.sv
module tlb_xlate_unit
   import tlb_xlate_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned PG_BITS   = 13,
   parameter int unsigned ENTRIES   = 64,
   parameter int unsigned WIN_LIMIT = 32'h2000,
   parameter bit          WIN_EN    = 1'b1,
   localparam int unsigned IDX_W    = $clog2(ENTRIES),
   localparam int unsigned VPN_W    = ADDR_W - PG_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              itlb_en,
   input  logic              dtlb_en,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_vaddr,
   input  logic [1:0]        req_kind,
   input  logic              req_super,
   input  logic              wr_en,
   input  logic              wr_tlb,
   input  logic              wr_word,
   input  logic [IDX_W-1:0]  wr_index,
   input  logic [ADDR_W-1:0] wr_data,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_paddr,
   output logic [2:0]        rsp_rights,
   output logic [1:0]        rsp_code,
   output logic [2:0]        rsp_exc,
   output logic [ADDR_W-1:0] fault_addr
);

   if (PG_BITS < 10 || PG_BITS >= ADDR_W) begin : g_bad_pg
      $error("tlb_xlate_unit: PG_BITS must leave room for permission bits and a page number");
   end
   if ((1 << IDX_W) != ENTRIES || ENTRIES < 2) begin : g_bad_ent
      $error("tlb_xlate_unit: ENTRIES must be a power of two of at least 2");
   end
   if (IDX_W > VPN_W) begin : g_bad_idx
      $error("tlb_xlate_unit: index wider than the virtual page number");
   end

   logic [VPN_W-1:0]  vpn;
   logic [IDX_W-1:0]  ridx;
   logic [ADDR_W-1:0] tag_rd [2];
   logic [ADDR_W-1:0] map_rd [2];

   assign vpn  = req_vaddr[ADDR_W-1:PG_BITS];
   assign ridx = vpn[IDX_W-1:0];

   // table 0 serves fetches, table 1 serves data
   for (genvar t = 0; t < 2; t++) begin : g_tbl
      logic sel;
      assign sel = wr_en && (wr_tlb == t[0]);
      tlb_slot_array #(.WORD_W(ADDR_W), .ENTRIES(ENTRIES)) u_arr (
         .clk    (clk),
         .rst_n  (rst_n),
         .we_tag (sel && !wr_word),
         .we_map (sel && wr_word),
         .widx   (wr_index),
         .wdata  (wr_data),
         .ridx   (ridx),
         .rd_tag (tag_rd[t]),
         .rd_map (map_rd[t])
      );
   end

   logic              is_fetch;
   logic [1:0]        chk_code;
   logic [2:0]        chk_rights;
   logic [VPN_W-1:0]  chk_ppn;

   assign is_fetch = (req_kind == ACC_FETCH);

   tlb_perm_check #(.ADDR_W(ADDR_W), .PG_BITS(PG_BITS)) u_chk (
      .tag_w   (is_fetch ? tag_rd[0] : tag_rd[1]),
      .map_w   (is_fetch ? map_rd[0] : map_rd[1]),
      .vpn     (vpn),
      .kind    (req_kind),
      .super_m (req_super),
      .code    (chk_code),
      .rights  (chk_rights),
      .ppn     (chk_ppn)
   );

   logic in_win;
   if (WIN_EN) begin : g_win
      assign in_win = req_super && (req_vaddr < ADDR_W'(WIN_LIMIT));
   end else begin : g_nowin
      assign in_win = 1'b0;
   end

   logic              bypass;
   logic [1:0]        n_code;
   logic [2:0]        n_rights;
   logic [ADDR_W-1:0] n_paddr;
   logic [2:0]        n_exc;

   assign bypass = in_win || !(is_fetch ? itlb_en : dtlb_en);

   always_comb begin
      if (bypass) begin
         n_code   = RES_OK;
         n_rights = 3'b011;
         n_paddr  = req_vaddr;
      end else if (chk_code == RES_OK) begin
         n_code   = RES_OK;
         n_rights = chk_rights;
         n_paddr  = {chk_ppn, req_vaddr[PG_BITS-1:0]};
      end else begin
         n_code   = chk_code;
         n_rights = '0;
         n_paddr  = '0;
      end
      unique case (n_code)
         RES_OK:      n_exc = EXC_NONE;
         RES_BADADDR: n_exc = is_fetch ? EXC_IFAULT : EXC_DFAULT;
         default:     n_exc = is_fetch ? EXC_IMISS  : EXC_DMISS;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_paddr  <= '0;
         rsp_rights <= '0;
         rsp_code   <= RES_OK;
         rsp_exc    <= EXC_NONE;
         fault_addr <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_paddr  <= n_paddr;
            rsp_rights <= n_rights;
            rsp_code   <= n_code;
            rsp_exc    <= n_exc;
            if (n_code != RES_OK) fault_addr <= req_vaddr;
         end
      end
   end

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
   import tlb_xlate_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned PG_BITS   = 13,
   parameter int unsigned WIN_LIMIT = 32'h2000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              itlb_en,
   input logic              dtlb_en,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_vaddr,
   input logic [1:0]        req_kind,
   input logic              req_super,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] rsp_paddr,
   input logic [2:0]        rsp_rights,
   input logic [1:0]        rsp_code,
   input logic [2:0]        rsp_exc,
   input logic [ADDR_W-1:0] fault_addr
);

   p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   p_fault_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code != RES_OK) |-> (rsp_paddr == '0 && rsp_rights == '0));
   p_offset_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !(req_super && req_vaddr < ADDR_W'(WIN_LIMIT))) |=>
      (rsp_code != RES_OK || rsp_paddr[PG_BITS-1:0] == $past(req_vaddr[PG_BITS-1:0])));
   p_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_super && req_vaddr < ADDR_W'(WIN_LIMIT)) |=>
      (rsp_code == RES_OK && rsp_paddr == $past(req_vaddr) && rsp_rights == 3'b011));
   p_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !itlb_en && !dtlb_en) |=>
      (rsp_code == RES_OK && rsp_paddr == $past(req_vaddr)));
   p_miss_class_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == ACC_FETCH) |=>
      (rsp_exc == EXC_NONE || rsp_exc == EXC_IMISS || rsp_exc == EXC_IFAULT));
   p_ok_no_exc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code == RES_OK) |-> rsp_exc == EXC_NONE);
   p_fault_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid) |=> (rsp_code == RES_OK || fault_addr == $past(req_vaddr)));
   p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_valid && rsp_code != RES_OK) |-> $stable(fault_addr) || $past(!rst_n) || rsp_valid);

endmodule

bind tlb_xlate_unit tlb_xlate_chk #(
   .ADDR_W(ADDR_W), .PG_BITS(PG_BITS), .WIN_LIMIT(WIN_LIMIT)
) u_tlb_xlate_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .itlb_en    (itlb_en),
   .dtlb_en    (dtlb_en),
   .req_valid  (req_valid),
   .req_vaddr  (req_vaddr),
   .req_kind   (req_kind),
   .req_super  (req_super),
   .rsp_valid  (rsp_valid),
   .rsp_paddr  (rsp_paddr),
   .rsp_rights (rsp_rights),
   .rsp_code   (rsp_code),
   .rsp_exc    (rsp_exc),
   .fault_addr (fault_addr)
);

// File: tb/tlb_xlate_unit_bench.sv
module tlb_xlate_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        itlb_en = 1'b0, dtlb_en = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0;
   logic        req_super = 1'b0;
   logic        wr_en = 1'b0, wr_tlb = 1'b0, wr_word = 1'b0;
   logic [5:0]  wr_index = '0;
   logic [31:0] wr_data = '0;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic [2:0]  rsp_rights;
   logic [1:0]  rsp_code;
   logic [2:0]  rsp_exc;
   logic [31:0] fault_addr;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_fault = '0;

   typedef struct packed {
      logic [31:0] paddr;
      logic [2:0]  rights;
      logic [1:0]  code;
      logic [2:0]  exc;
      logic [31:0] fault;
   } exp_t;

   exp_t  exp_q [$];
   string tag_q [$];

   always #2 clk = ~clk;

   tlb_xlate_unit u_tlb_xlate_unit (
      .clk(clk), .rst_n(rst_n), .itlb_en(itlb_en), .dtlb_en(dtlb_en),
      .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
      .req_super(req_super), .wr_en(wr_en), .wr_tlb(wr_tlb), .wr_word(wr_word),
      .wr_index(wr_index), .wr_data(wr_data), .rsp_valid(rsp_valid),
      .rsp_paddr(rsp_paddr), .rsp_rights(rsp_rights), .rsp_code(rsp_code),
      .rsp_exc(rsp_exc), .fault_addr(fault_addr)
   );

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic wr(input logic tbl, input logic word, input logic [5:0] idx,
                     input logic [31:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_tlb = tbl; wr_word = word; wr_index = idx; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic send(input string tag, input logic [31:0] va, input logic [1:0] kind,
                       input logic sup, input logic [1:0] code, input logic [31:0] pa,
                       input logic [2:0] rt, input logic [2:0] exc);
      exp_t e;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_super = sup;
      if (code != 2'd0) exp_fault = va;
      e.paddr = pa; e.rights = rt; e.code = code; e.exc = exc; e.fault = exp_fault;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // monitor: results are registered one edge after the request edge
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R11 unexpected response: actual=1 expected=0");
         end else begin
            exp_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({t, " code"},   {30'd0, rsp_code},   {30'd0, e.code});
            check({t, " paddr"},  rsp_paddr,           e.paddr);
            check({t, " rights"}, {29'd0, rsp_rights}, {29'd0, e.rights});
            check({t, " exc"},    {29'd0, rsp_exc},    {29'd0, e.exc});
            check({t, " fault_addr R9"}, fault_addr, e.fault);
         end
      end
   end

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10 rsp_valid at reset", {31'd0, rsp_valid}, 32'd0);
      check("R10 fault_addr at reset", fault_addr, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 idle no response", {31'd0, rsp_valid}, 32'd0);

      // R10 translation disabled: pass through
      send("R10 pass load", 32'h1234_5678, 2'd1, 1'b0, 2'd0, 32'h1234_5678, 3'b011, 3'd0);
      send("R10 pass fetch", 32'hCAFE_0004, 2'd0, 1'b0, 2'd0, 32'hCAFE_0004, 3'b011, 3'd0);

      itlb_en = 1'b1; dtlb_en = 1'b1;
      // cleared tables: R10 R2 R3 R8
      send("R2 R10 cleared nomatch", 32'h0000_4000, 2'd1, 1'b0, 2'd1, 32'd0, 3'd0, 3'd2);
      send("R3 R10 cleared invalid fetch", 32'h0000_1000, 2'd0, 1'b0, 2'd2, 32'd0, 3'd0, 3'd1);
      // R7 window and its boundary
      send("R7 window store", 32'h0000_1ABC, 2'd2, 1'b1, 2'd0, 32'h0000_1ABC, 3'b011, 3'd0);
      send("R7 boundary 0x2000", 32'h0000_2000, 2'd1, 1'b1, 2'd1, 32'd0, 3'd0, 3'd2);

      // data slot 5: vpn 0x40005, read-only (SR bit8, UR bit6)
      wr(1'b1, 1'b0, 6'd5, 32'h8000_A001);
      wr(1'b1, 1'b1, 6'd5, 32'h2468_A140);
      send("R5 R6 R1 user load hit", 32'h8000_A123, 2'd1, 1'b0, 2'd0, 32'h2468_A123, 3'b001, 3'd0);
      send("R5 R8 user store no write", 32'h8000_A123, 2'd2, 1'b0, 2'd3, 32'd0, 3'd0, 3'd4);
      send("R5 super store no write", 32'h8000_A200, 2'd2, 1'b1, 2'd3, 32'd0, 3'd0, 3'd4);
      send("R12 fetch table untouched", 32'h8000_A123, 2'd0, 1'b1, 2'd1, 32'd0, 3'd0, 3'd1);
      send("R1 R2 alias same index", 32'h0000_A010, 2'd1, 1'b0, 2'd1, 32'd0, 3'd0, 3'd2);

      // add user write (bit7); super keeps read only
      wr(1'b1, 1'b1, 6'd5, 32'h2468_A1C0);
      send("R5 user store ok", 32'h8000_BFFF, 2'd2, 1'b0, 2'd0, 32'h2468_BFFF, 3'b011, 3'd0);
      send("R5 super load ok", 32'h8000_A008, 2'd1, 1'b1, 2'd0, 32'h2468_A008, 3'b001, 3'd0);

      // fetch slot 9: vpn 0x7FF09, supervisor execute only
      wr(1'b0, 1'b0, 6'd9, 32'hFFE1_2001);
      wr(1'b0, 1'b1, 6'd9, 32'h0157_8080);
      send("R4 R6 super fetch ok", 32'hFFE1_2FFC, 2'd0, 1'b1, 2'd0, 32'h0157_8FFC, 3'b100, 3'd0);
      send("R4 R8 user fetch fault", 32'hFFE1_2000, 2'd0, 1'b0, 2'd3, 32'd0, 3'd0, 3'd3);
      send("R12 data table untouched", 32'hFFE1_2000, 2'd1, 1'b1, 2'd1, 32'd0, 3'd0, 3'd2);
      wr(1'b0, 1'b1, 6'd9, 32'h0157_8040);
      send("R4 user fetch ok", 32'hFFE1_2010, 2'd0, 1'b0, 2'd0, 32'h0157_8010, 3'b100, 3'd0);
      send("R4 super fetch no exec", 32'hFFE1_2020, 2'd0, 1'b1, 2'd3, 32'd0, 3'd0, 3'd3);

      // R3 clear valid bit of data slot 5
      wr(1'b1, 1'b0, 6'd5, 32'h8000_A000);
      send("R3 invalidated load", 32'h8000_A123, 2'd1, 1'b0, 2'd2, 32'd0, 3'd0, 3'd2);

      // R10 data translation off while fetch stays on
      dtlb_en = 1'b0;
      send("R10 data disabled", 32'h8000_A123, 2'd1, 1'b0, 2'd0, 32'h8000_A123, 3'b011, 3'd0);
      send("R10 fetch still on", 32'hFFE1_2030, 2'd0, 1'b0, 2'd0, 32'h0157_8030, 3'b100, 3'd0);

      repeat (3) @(negedge clk);
      check("R11 all responses seen", exp_q.size(), 32'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule